// File: doc/BRIEF.md
# Iterative Multiply/Divide Unit with Paired Result Registers

This block performs 32-bit integer multiplication and division over many clock cycles and keeps the outcome in two dedicated result registers, called HI and LO. A pipeline hands it an operation code, two operands and a one-cycle start pulse. It then stalls on the busy flag, or carries on with other work and reads HI or LO later through a move-from instruction. Multiplication fills HI:LO with a 64-bit product. Division places the quotient in LO and the remainder in HI.

Internally the operands are reduced to magnitudes first. A radix-2 shift-add multiplier or a restoring divider then runs for one step per bit. A final cycle applies the result signs and writes both registers at once. Division by zero raises no trap and gives a fixed result. A start pulse that arrives while an operation is running is dropped.

Top module: `md_unit`

## Requirements
- R1: After a synchronous reset, busy is low and both HI and LO read zero.
- R2: Operation code 2'b00 is the signed multiply. HI receives bits 63..32 of the two's-complement product of the operands and LO receives bits 31..0.
- R3: Operation code 2'b01 is the unsigned multiply. The 64-bit unsigned product is split between HI and LO in the same way as for R2.
- R4: Operation code 2'b10 is the signed divide. LO receives the quotient, rounded toward zero, and HI receives a remainder that carries the sign of the dividend. For the most negative dividend divided by -1, the quotient wraps to 0x80000000 and the remainder is 0.
- R5: Operation code 2'b11 is the unsigned divide. LO receives the unsigned quotient and HI receives the unsigned remainder.
- R6: For either divide with a zero divisor, LO becomes 0xFFFFFFFF and HI becomes the unmodified dividend.
- R7: A start pulse accepted at a clock edge drives busy high from that edge for exactly 33 cycles. HI and LO hold the new result from the edge where busy falls.
- R8: A start pulse that arrives while busy is high is ignored. It neither changes the result nor extends busy, and HI and LO keep their previous values until the running operation completes.
- R9: While the unit is idle and start is low, HI and LO do not change, whatever the operands and operation code do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse, accepted only while not busy |
| op_i | input | 2 | Operation code: 00 signed mul, 01 unsigned mul, 10 signed div, 11 unsigned div |
| src_a_i | input | 32 | Multiplicand or dividend |
| src_b_i | input | 32 | Multiplier or divisor |
| busy_o | output | 1 | High while an operation is in progress |
| hi_o | output | 32 | HI register: upper product half or remainder |
| lo_o | output | 32 | LO register: lower product half or quotient |

## Verification
The bench targets the sign corners of signed division, which are negative dividend, negative divisor, both negative, and the most negative value divided by -1. A design that took the sign of the remainder from the divisor, or negated both results together, gives remainders of the wrong sign there. The multiply stimulus includes the most negative value squared and all-ones times all-ones. These catch a product-sign fix that is applied to only one half, and a multiplier that drops its carry into the top bit. Zero divisors are sent for both signednesses, so a design that let the sign fix-up alter the defined result would return a negated quotient or remainder. Finally, a start pulse is sent in the middle of an operation and HI/LO are sampled while it runs. A unit that restarted, or that exposed partial results, would end up with the wrong result or the wrong busy length.

// File: rtl/md_pkg.sv
package md_pkg;
  typedef enum logic [1:0] {
    MD_MUL_S = 2'b00,
    MD_MUL_U = 2'b01,
    MD_DIV_S = 2'b10,
    MD_DIV_U = 2'b11
  } md_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } md_state_e;
endpackage

// File: rtl/md_sign_prep.sv
module md_sign_prep
  import md_pkg::*;
#(
  parameter int W = 32
) (
  input  md_op_e       op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] mag_a_o,
  output logic [W-1:0] mag_b_o,
  output logic         neg_res_o,
  output logic         neg_rem_o,
  output logic         is_div_o
);
  logic is_signed;
  logic a_neg;
  logic b_neg;

  always_comb begin
    is_signed = (op_i == MD_MUL_S) || (op_i == MD_DIV_S);
    is_div_o  = (op_i == MD_DIV_S) || (op_i == MD_DIV_U);
    a_neg     = is_signed && a_i[W-1];
    b_neg     = is_signed && b_i[W-1];
    mag_a_o   = a_neg ? (~a_i + 1'b1) : a_i;
    mag_b_o   = b_neg ? (~b_i + 1'b1) : b_i;
    neg_res_o = a_neg ^ b_neg;
    neg_rem_o = a_neg;
  end
endmodule

// File: rtl/md_mul_core.sv
module md_mul_core #(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load_i,
  input  logic           step_i,
  input  logic [W-1:0]   mcand_i,
  input  logic [W-1:0]   mplier_i,
  output logic [2*W-1:0] prod_o
);
  logic [W-1:0] mcand_q;
  logic [W-1:0] acc_q;
  logic [W-1:0] mq_q;
  logic [W:0]   sum;

  always_comb begin
    sum = {1'b0, acc_q} + (mq_q[0] ? {1'b0, mcand_q} : '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mcand_q <= '0;
      acc_q   <= '0;
      mq_q    <= '0;
    end else if (load_i) begin
      mcand_q <= mcand_i;
      acc_q   <= '0;
      mq_q    <= mplier_i;
    end else if (step_i) begin
      acc_q <= sum[W:1];
      mq_q  <= {sum[0], mq_q[W-1:1]};
    end
  end

  assign prod_o = {acc_q, mq_q};
endmodule

// File: rtl/md_div_core.sv
module md_div_core #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic         step_i,
  input  logic [W-1:0] dvnd_i,
  input  logic [W-1:0] dvsr_i,
  output logic [W-1:0] quo_o,
  output logic [W-1:0] rem_o
);
  logic [W-1:0] dvsr_q;
  logic [W-1:0] rem_q;
  logic [W-1:0] quo_q;
  logic [W:0]   shifted;
  logic [W+1:0] diff;
  logic         fits;

  always_comb begin
    shifted = {rem_q, quo_q[W-1]};
    diff    = {1'b0, shifted} - {2'b00, dvsr_q};
    fits    = !diff[W+1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dvsr_q <= '0;
      rem_q  <= '0;
      quo_q  <= '0;
    end else if (load_i) begin
      dvsr_q <= dvsr_i;
      rem_q  <= '0;
      quo_q  <= dvnd_i;
    end else if (step_i) begin
      if (fits) begin
        rem_q <= diff[W-1:0];
        quo_q <= {quo_q[W-2:0], 1'b1};
      end else begin
        rem_q <= shifted[W-1:0];
        quo_q <= {quo_q[W-2:0], 1'b0};
      end
    end
  end

  assign quo_o = quo_q;
  assign rem_o = rem_q;

  // restoring invariant: partial remainder stays below a nonzero divisor
  assert_rem_below_divisor_R5: assert property (@(posedge clk) disable iff (rst)
    (dvsr_q != '0) |-> (rem_q < dvsr_q));
endmodule

// File: rtl/md_unit.sv
module md_unit
  import md_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start_i,
  input  logic [1:0]   op_i,
  input  logic [W-1:0] src_a_i,
  input  logic [W-1:0] src_b_i,
  output logic         busy_o,
  output logic [W-1:0] hi_o,
  output logic [W-1:0] lo_o
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  md_state_e     state_q;
  logic [CW-1:0] cnt_q;
  logic          busy_q;
  logic [W-1:0]  hi_q;
  logic [W-1:0]  lo_q;
  logic          neg_res_q;
  logic          neg_rem_q;
  logic          is_div_q;
  logic          div0_q;
  logic [W-1:0]  dvnd_raw_q;

  logic [W-1:0]   mag_a;
  logic [W-1:0]   mag_b;
  logic           neg_res;
  logic           neg_rem;
  logic           is_div;
  logic           accept;
  logic           step;
  logic [2*W-1:0] prod;
  logic [W-1:0]   quo;
  logic [W-1:0]   rem;
  logic [2*W-1:0] prod_fix;
  logic [W-1:0]   quo_fix;
  logic [W-1:0]   rem_fix;

  md_sign_prep #(.W(W)) u_prep (
    .op_i      (md_op_e'(op_i)),
    .a_i       (src_a_i),
    .b_i       (src_b_i),
    .mag_a_o   (mag_a),
    .mag_b_o   (mag_b),
    .neg_res_o (neg_res),
    .neg_rem_o (neg_rem),
    .is_div_o  (is_div)
  );

  assign accept = start_i && (state_q == ST_IDLE);
  assign step   = (state_q == ST_RUN);

  md_mul_core #(.W(W)) u_mul (
    .clk      (clk),
    .rst      (rst),
    .load_i   (accept),
    .step_i   (step),
    .mcand_i  (mag_a),
    .mplier_i (mag_b),
    .prod_o   (prod)
  );

  md_div_core #(.W(W)) u_div (
    .clk    (clk),
    .rst    (rst),
    .load_i (accept),
    .step_i (step),
    .dvnd_i (mag_a),
    .dvsr_i (mag_b),
    .quo_o  (quo),
    .rem_o  (rem)
  );

  always_comb begin
    prod_fix = neg_res_q ? (~prod + 1'b1) : prod;
    quo_fix  = neg_res_q ? (~quo + 1'b1) : quo;
    rem_fix  = neg_rem_q ? (~rem + 1'b1) : rem;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      busy_q     <= 1'b0;
      hi_q       <= '0;
      lo_q       <= '0;
      neg_res_q  <= 1'b0;
      neg_rem_q  <= 1'b0;
      is_div_q   <= 1'b0;
      div0_q     <= 1'b0;
      dvnd_raw_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            state_q    <= ST_RUN;
            cnt_q      <= '0;
            busy_q     <= 1'b1;
            neg_res_q  <= neg_res;
            neg_rem_q  <= neg_rem;
            is_div_q   <= is_div;
            div0_q     <= (src_b_i == '0);
            dvnd_raw_q <= src_a_i;
          end
        end
        ST_RUN: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == LAST) state_q <= ST_FIN;
        end
        ST_FIN: begin
          if (!is_div_q) begin
            hi_q <= prod_fix[2*W-1:W];
            lo_q <= prod_fix[W-1:0];
          end else if (div0_q) begin
            hi_q <= dvnd_raw_q;
            lo_q <= '1;
          end else begin
            hi_q <= rem_fix;
            lo_q <= quo_fix;
          end
          busy_q  <= 1'b0;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = busy_q;
  assign hi_o   = hi_q;
  assign lo_o   = lo_q;

  assert_busy_rise_R7: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o) |=> busy_o);

  assert_busy_drop_R7: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_FIN) |=> !busy_o);

  assert_count_advance_R7: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RUN && cnt_q != LAST) |=> (state_q == ST_RUN && cnt_q == $past(cnt_q) + 1'b1));

  assert_hold_while_running_R8: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RUN) |=> ($stable(hi_o) && $stable(lo_o) && busy_o));

  assert_hold_while_idle_R9: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && !start_i) |=> ($stable(hi_o) && $stable(lo_o)));
endmodule

// File: tb/tb_md_unit.sv
module tb_md_unit;
  localparam int W = 32;
  localparam int BUSY_LEN = W + 1;

  typedef struct {
    logic [W-1:0] hi;
    logic [W-1:0] lo;
    string        tag;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start_i = 1'b0;
  logic [1:0]   op_i = 2'b00;
  logic [W-1:0] src_a_i = '0;
  logic [W-1:0] src_b_i = '0;
  logic         busy_o;
  logic [W-1:0] hi_o;
  logic [W-1:0] lo_o;

  int checks = 0;
  int fails = 0;
  bit done_flag = 0;
  exp_t sb_q[$];

  always #2.5 clk = ~clk;

  md_unit #(.W(W)) dut (
    .clk(clk), .rst(rst), .start_i(start_i), .op_i(op_i),
    .src_a_i(src_a_i), .src_b_i(src_b_i),
    .busy_o(busy_o), .hi_o(hi_o), .lo_o(lo_o)
  );

  task automatic check(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  function automatic exp_t model(input logic [1:0] op, input logic [W-1:0] a, input logic [W-1:0] b, input string tag);
    exp_t e;
    longint p, q, r;
    logic [63:0] u;
    e.tag = tag;
    case (op)
      2'b00: begin p = longint'($signed(a)) * longint'($signed(b)); e.hi = p[63:32]; e.lo = p[31:0]; end
      2'b01: begin u = {32'b0, a} * {32'b0, b}; e.hi = u[63:32]; e.lo = u[31:0]; end
      2'b10: begin
        if (b == 0) begin e.hi = a; e.lo = '1; end
        else begin
          q = longint'($signed(a)) / longint'($signed(b));
          r = longint'($signed(a)) % longint'($signed(b));
          e.hi = r[31:0]; e.lo = q[31:0];
        end
      end
      default: begin
        if (b == 0) begin e.hi = a; e.lo = '1; end
        else begin e.hi = a % b; e.lo = a / b; end
      end
    endcase
    return e;
  endfunction

  task automatic pulse_start(input logic [1:0] op, input logic [W-1:0] a, input logic [W-1:0] b);
    @(negedge clk);
    op_i = op; src_a_i = a; src_b_i = b; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy_o) @(negedge clk);
  endtask

  task automatic run_op(input logic [1:0] op, input logic [W-1:0] a, input logic [W-1:0] b, input string tag);
    sb_q.push_back(model(op, a, b, tag));
    pulse_start(op, a, b);
    wait_idle();
  endtask

  // monitor: counts busy cycles and compares results when busy falls
  int  busy_cnt = 0;
  bit  busy_prev = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (busy_o) busy_cnt++;
      if (!busy_o && busy_prev) begin
        check(busy_cnt == BUSY_LEN, "R7 busy length", 64'(busy_cnt), 64'(BUSY_LEN));
        if (sb_q.size() == 0) begin
          check(1'b0, "R8 unexpected completion", {hi_o, lo_o}, 64'd0);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          check({hi_o, lo_o} == {e.hi, e.lo}, e.tag, {hi_o, lo_o}, {e.hi, e.lo});
        end
        busy_cnt = 0;
      end
      busy_prev = busy_o;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog expired", 64'd0, 64'd1);
    finish_run();
  end

  initial begin
    logic [W-1:0] old_hi, old_lo;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(busy_o == 1'b0, "R1 busy after reset", 64'(busy_o), 64'd0);
    check({hi_o, lo_o} == 64'd0, "R1 HI/LO after reset", {hi_o, lo_o}, 64'd0);

    // R2 signed multiply
    run_op(2'b00, 32'd3, -32'sd5, "R2 3*-5");
    run_op(2'b00, -32'sd7, -32'sd9, "R2 -7*-9");
    run_op(2'b00, 32'h8000_0000, 32'h8000_0000, "R2 min*min");
    run_op(2'b00, 32'h7FFF_FFFF, 32'hFFFF_FFFF, "R2 max*-1");
    run_op(2'b00, 32'd0, 32'hDEAD_BEEF, "R2 zero operand");
    // R3 unsigned multiply
    run_op(2'b01, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R3 ones*ones");
    run_op(2'b01, 32'h1234_5678, 32'h9ABC_DEF0, "R3 mixed");
    run_op(2'b01, 32'd1, 32'h8000_0001, "R3 identity");
    // R4 signed divide
    run_op(2'b10, 32'd7, 32'd2, "R4 7/2");
    run_op(2'b10, -32'sd7, 32'd2, "R4 -7/2");
    run_op(2'b10, 32'd7, -32'sd2, "R4 7/-2");
    run_op(2'b10, -32'sd7, -32'sd2, "R4 -7/-2");
    run_op(2'b10, 32'h8000_0000, 32'hFFFF_FFFF, "R4 min/-1");
    // R5 unsigned divide
    run_op(2'b11, 32'd100, 32'd7, "R5 100/7");
    run_op(2'b11, 32'hFFFF_FFFF, 32'd1, "R5 ones/1");
    run_op(2'b11, 32'd3, 32'd10, "R5 small/large");
    run_op(2'b11, 32'hFFFF_FFFE, 32'h8000_0000, "R5 large operands");
    // R6 divide by zero
    run_op(2'b10, 32'd5, 32'd0, "R6 signed 5/0");
    run_op(2'b10, -32'sd5, 32'd0, "R6 signed -5/0");
    run_op(2'b11, 32'h8000_0000, 32'd0, "R6 unsigned /0");

    // R8 start during busy is ignored, HI/LO hold old values meanwhile
    old_hi = hi_o; old_lo = lo_o;
    sb_q.push_back(model(2'b01, 32'd6, 32'd7, "R8 first op result"));
    pulse_start(2'b01, 32'd6, 32'd7);
    repeat (4) @(negedge clk);
    check({hi_o, lo_o} == {old_hi, old_lo}, "R8 HI/LO mid-run", {hi_o, lo_o}, {old_hi, old_lo});
    op_i = 2'b11; src_a_i = 32'd999; src_b_i = 32'd3; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check({hi_o, lo_o} == {old_hi, old_lo}, "R8 HI/LO after ignored start", {hi_o, lo_o}, {old_hi, old_lo});
    wait_idle();
    repeat (3) @(negedge clk);
    check(busy_o == 1'b0, "R8 no restart after completion", 64'(busy_o), 64'd0);

    // R9 idle: operand and op changes without start leave HI/LO alone
    old_hi = hi_o; old_lo = lo_o;
    op_i = 2'b10; src_a_i = 32'h5555_AAAA; src_b_i = 32'd0;
    repeat (3) @(negedge clk);
    op_i = 2'b00; src_a_i = 32'hFFFF_0000; src_b_i = 32'h1234_0000;
    repeat (3) @(negedge clk);
    check({hi_o, lo_o} == {old_hi, old_lo}, "R9 idle hold", {hi_o, lo_o}, {old_hi, old_lo});
    check(busy_o == 1'b0, "R9 idle busy", 64'(busy_o), 64'd0);

    repeat (2) @(negedge clk);
    check(sb_q.size() == 0, "R7 all results delivered", 64'(sb_q.size()), 64'd0);
    finish_run();
  end
endmodule